// File: doc/BRIEF.md
# Synchronous Clock Stop Controller

This block sits between a clock synthesizer and its output drivers. It switches a group of CPU clock outputs and a group of PCI clock outputs on and off in response to active-low stop requests and an active-low power-down request. Every switch happens only while the clock concerned is low. As a result, no output ever shows a pulse that is shortened, stretched or split.

Each stop request is captured on a rising edge of the free-running PCI clock. The CPU clock runs at two or three times the PCI rate, and its rising edges coincide with PCI rising edges. Because of that alignment, the captured CPU request moves into the CPU domain through a plain two-register pipeline.

Power-down is asynchronous. It is synchronized into the PCI domain, parks every output (including the ungated PCI output) and drops the oscillator/PLL enable. When power-down is released, the enable returns first. The clocks restart only after a parameterized number of PCI rising edges, which stands in for the PLL lock time.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While `cpu_stop_ni` is low and power-down is inactive, every bit of `cpu_clk_o` stays low, and `pci_clk_o` and `pci_free_o` keep toggling at the PCI rate.
- R2: While `pci_stop_ni` is low and power-down is inactive, all seven bits of `pci_clk_o` stay low, and `pci_free_o` and `cpu_clk_o` keep toggling.
- R3: A stop or restart request changes its group's state no earlier than the first PCI rising edge after the request changes. From the fourth PCI rising edge onward, the group is in its new state.
- R4: While `pwr_dn_ni` is low, `osc_en_o` is low within four PCI rising edges. All twelve clock outputs are parked low within seven PCI rising edges, and they stay low whatever the stop requests do.
- R5: Every high pulse on an output lasts exactly half a period of its source clock. Every low interval is a whole multiple of that half period.
- R6: After `pwr_dn_ni` returns high, `osc_en_o` rises within four PCI rising edges. All outputs then remain low for at least `LOCK_EDGES` PCI periods, and all are running within five further periods.
- R7: During and right after reset, `osc_en_o` is high. With no request active, all outputs run once the lock wait has elapsed. If power-down is held low through reset, no output ever pulses and `osc_en_o` falls.
- R8: A stop request held low through reset keeps its group parked from reset onward. The other groups start normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_i | input | 1 | Free-running CPU clock, 2x or 3x PCI, rising edges aligned with PCI |
| pci_clk_i | input | 1 | Free-running PCI clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_stop_ni | input | 1 | Active-low CPU group stop request, synchronous to PCI |
| pci_stop_ni | input | 1 | Active-low PCI group stop request, synchronous to PCI |
| pwr_dn_ni | input | 1 | Active-low power-down request, asynchronous |
| cpu_clk_o | output | 4 | Gated CPU clocks |
| pci_clk_o | output | 7 | Gated PCI clocks |
| pci_free_o | output | 1 | PCI clock stopped only by power-down |
| osc_en_o | output | 1 | Oscillator/PLL enable |

## Verification
Two situations are hard to reach from the ports. The first is a stop request overlapping power-down. The second is the short gap right after the oscillator enable returns, during which every output must still be held. The bench drives power-down low, toggles both stop requests while everything is parked, then polls `osc_en_o` at PCI falling edges after release. It counts output edges over a window exactly `LOCK_EDGES` PCI periods long that starts just after the enable is seen high. A monitor on every output measures each high pulse and low interval against the source clock's half period, so a truncated pulse at any stop, restart or power-down is caught.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_DOWN = 2'd1,
    PS_LOCK = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/clk_stop_sync2.sv
module clk_stop_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/clk_gate_grp.sv
module clk_gate_grp #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic         en_o,
  output logic [N-1:0] clk_o
);
  logic en_q;

  // enable moves only on the falling edge, so it is stable across the high phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  assign en_o = en_q;

  for (genvar g = 0; g < N; g++) begin : g_lane
    assign clk_o[g] = clk_i & en_q;
  end
endmodule

// File: rtl/clk_stop_pwr.sv
module clk_stop_pwr
  import clk_stop_pkg::*;
#(
  parameter int LOCK_EDGES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_dn_ni,
  output logic run_o,
  output logic osc_en_o
);
  localparam int CNT_W = (LOCK_EDGES > 2) ? $clog2(LOCK_EDGES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_EDGES - 1);

  logic pwr_s1_q, pwr_s2_q;
  pwr_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // async request: reset to "powered" so reset alone never forces a shutdown
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_s1_q <= 1'b1;
      pwr_s2_q <= 1'b1;
    end else begin
      pwr_s1_q <= pwr_dn_ni;
      pwr_s2_q <= pwr_s1_q;
    end
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PS_RUN:  if (!pwr_s2_q) state_d = PS_DOWN;
      PS_DOWN: if (pwr_s2_q) begin
        state_d = PS_LOCK;
        cnt_d   = '0;
      end
      PS_LOCK: begin
        if (!pwr_s2_q)             state_d = PS_DOWN;
        else if (cnt_q == CNT_LAST) state_d = PS_RUN;
        else                        cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = PS_DOWN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_LOCK;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign run_o    = (state_q == PS_RUN);
  assign osc_en_o = (state_q != PS_DOWN);

  p_down_stops_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_s2_q |=> !run_o);

  p_osc_before_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> (osc_en_o && $past(osc_en_o)));
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
  parameter int N_CPU      = 4,
  parameter int N_PCI      = 7,
  parameter int LOCK_EDGES = 16
) (
  input  logic             cpu_clk_i,
  input  logic             pci_clk_i,
  input  logic             rst_ni,
  input  logic             cpu_stop_ni,
  input  logic             pci_stop_ni,
  input  logic             pwr_dn_ni,
  output logic [N_CPU-1:0] cpu_clk_o,
  output logic [N_PCI-1:0] pci_clk_o,
  output logic             pci_free_o,
  output logic             osc_en_o
);
  logic run;
  logic cpu_req_q, pci_req_q;
  logic cpu_go;
  logic cpu_en, pci_en, free_en;

  clk_stop_pwr #(.LOCK_EDGES(LOCK_EDGES)) u_pwr (
    .clk_i    (pci_clk_i),
    .rst_ni   (rst_ni),
    .pwr_dn_ni(pwr_dn_ni),
    .run_o    (run),
    .osc_en_o (osc_en_o)
  );

  // requests are decided on the free-running PCI rising edge
  always_ff @(posedge pci_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_req_q <= 1'b0;
      pci_req_q <= 1'b0;
    end else begin
      cpu_req_q <= cpu_stop_ni & run;
      pci_req_q <= pci_stop_ni & run;
    end
  end

  // rising edges coincide, so a two-register pipeline carries it to the CPU side
  clk_stop_sync2 u_cpu_sync (
    .clk_i (cpu_clk_i),
    .rst_ni(rst_ni),
    .d_i   (cpu_req_q),
    .q_o   (cpu_go)
  );

  clk_gate_grp #(.N(N_CPU)) u_cpu_gate (
    .clk_i (cpu_clk_i),
    .rst_ni(rst_ni),
    .en_i  (cpu_go),
    .en_o  (cpu_en),
    .clk_o (cpu_clk_o)
  );

  clk_gate_grp #(.N(N_PCI)) u_pci_gate (
    .clk_i (pci_clk_i),
    .rst_ni(rst_ni),
    .en_i  (pci_req_q),
    .en_o  (pci_en),
    .clk_o (pci_clk_o)
  );

  clk_gate_grp #(.N(1)) u_free_gate (
    .clk_i (pci_clk_i),
    .rst_ni(rst_ni),
    .en_i  (run),
    .en_o  (free_en),
    .clk_o (pci_free_o)
  );

  p_cpu_park_r1: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    (!cpu_go && $past(!cpu_go)) |-> !cpu_en);

  p_pci_park_r2: assert property (@(posedge pci_clk_i) disable iff (!rst_ni)
    (!pci_req_q && $past(!pci_req_q)) |-> !pci_en);

  p_free_runs_r2: assert property (@(posedge pci_clk_i) disable iff (!rst_ni)
    (run && $past(run)) |-> free_en);

  p_pd_overrides_r4: assert property (@(posedge pci_clk_i) disable iff (!rst_ni)
    !run |=> (!cpu_req_q && !pci_req_q));
endmodule

// File: tb/clk_stop_ctrl_test.sv
`timescale 1ns/1ps
module clk_stop_ctrl_test;
  localparam int L      = 6;
  localparam int PCI_PD = 20;

  logic cpu_clk = 1'b0;
  logic pci_clk = 1'b0;
  logic rst_n, cpu_stop_n, pci_stop_n, pd_n;
  logic [3:0] cpu_o;
  logic [6:0] pci_o;
  logic free_o, osc_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int cpu_cnt [4];
  int pci_cnt [7];
  int free_cnt;

  clk_stop_ctrl #(.N_CPU(4), .N_PCI(7), .LOCK_EDGES(L)) uut (
    .cpu_clk_i  (cpu_clk),
    .pci_clk_i  (pci_clk),
    .rst_ni     (rst_n),
    .cpu_stop_ni(cpu_stop_n),
    .pci_stop_ni(pci_stop_n),
    .pwr_dn_ni  (pd_n),
    .cpu_clk_o  (cpu_o),
    .pci_clk_o  (pci_o),
    .pci_free_o (free_o),
    .osc_en_o   (osc_en)
  );

  // 50 MHz PCI, CPU at twice the rate, rising edges aligned
  initial forever #10 pci_clk = ~pci_clk;
  initial forever #5  cpu_clk = ~cpu_clk;

  initial free_cnt = 0;
  initial begin
    foreach (cpu_cnt[i]) cpu_cnt[i] = 0;
    foreach (pci_cnt[i]) pci_cnt[i] = 0;
  end
  for (genvar g = 0; g < 4; g++) begin : g_ccnt
    always @(posedge cpu_o[g]) cpu_cnt[g]++;
  end
  for (genvar g = 0; g < 7; g++) begin : g_pcnt
    always @(posedge pci_o[g]) pci_cnt[g]++;
  end
  always @(posedge free_o) free_cnt++;

  // R5: pulse-shape monitor on every output
  wire [11:0] all_o = {free_o, pci_o, cpu_o};
  for (genvar g = 0; g < 12; g++) begin : g_mon
    localparam time HALF = (g < 4) ? 5 : 10;
    time t_rise, t_fall;
    bit  seen_rise = 0, seen_fall = 0;
    always @(posedge all_o[g]) begin
      if (seen_fall) begin
        checks++;
        if ((($time - t_fall) % HALF) != 0 || ($time - t_fall) == 0) begin
          fails++;
          $display("FAIL R5 low interval out%0d actual=%0t expected multiple of %0t",
                   g, $time - t_fall, HALF);
        end
      end
      t_rise = $time;
      seen_rise = 1;
    end
    always @(negedge all_o[g]) begin
      if (seen_rise) begin
        checks++;
        if (($time - t_rise) != HALF) begin
          fails++;
          $display("FAIL R5 high pulse out%0d actual=%0t expected=%0t",
                   g, $time - t_rise, HALF);
        end
      end
      t_fall = $time;
      seen_fall = 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // window starts 2 ns after a PCI falling edge, so no edge sits on its ends
  task automatic observe(input int w, input bit cpu_run, input bit pci_run,
                         input bit free_run, input string req);
    int c0 [4];
    int p0 [7];
    int f0;
    c0 = cpu_cnt;
    p0 = pci_cnt;
    f0 = free_cnt;
    #(PCI_PD * w);
    for (int i = 0; i < 4; i++)
      check(cpu_cnt[i] - c0[i] == (cpu_run ? 2 * w : 0),
            {req, " cpu edges"}, cpu_cnt[i] - c0[i], cpu_run ? 2 * w : 0);
    for (int i = 0; i < 7; i++)
      check(pci_cnt[i] - p0[i] == (pci_run ? w : 0),
            {req, " pci edges"}, pci_cnt[i] - p0[i], pci_run ? w : 0);
    check(free_cnt - f0 == (free_run ? w : 0),
          {req, " free edges"}, free_cnt - f0, free_run ? w : 0);
  endtask

  task automatic sync_pt();
    @(negedge pci_clk);
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    rst_n = 0; cpu_stop_n = 1; pci_stop_n = 1; pd_n = 1;
    #35;
    check(osc_en === 1'b1, "R7 osc_en in reset", int'(osc_en), 1);
    check(cpu_o === 4'h0 && pci_o === 7'h0 && free_o === 1'b0,
          "R7 outputs parked in reset", int'({cpu_o, pci_o, free_o}), 0);
    sync_pt();
    rst_n = 1;
    #(PCI_PD * (L + 6));
    check(osc_en === 1'b1, "R7 osc_en after reset", int'(osc_en), 1);
    observe(6, 1, 1, 1, "R7 running");

    // R1 / R3: CPU stop then restart
    cpu_stop_n = 0;
    observe(1, 1, 1, 1, "R3 cpu stop before edge");
    #60;
    observe(6, 0, 1, 1, "R1 cpu parked");
    cpu_stop_n = 1;
    observe(1, 0, 1, 1, "R3 cpu restart before edge");
    #60;
    observe(6, 1, 1, 1, "R3 cpu restarted");

    // R2 / R3: PCI stop then restart
    pci_stop_n = 0;
    observe(1, 1, 1, 1, "R3 pci stop before edge");
    #60;
    observe(6, 1, 0, 1, "R2 pci parked");
    pci_stop_n = 1;
    observe(1, 1, 0, 1, "R3 pci restart before edge");
    #60;
    observe(4, 1, 1, 1, "R3 pci restarted");

    // both stops together
    cpu_stop_n = 0; pci_stop_n = 0;
    #80;
    observe(4, 0, 0, 1, "R1 both stopped");
    cpu_stop_n = 1; pci_stop_n = 1;
    #100;
    observe(4, 1, 1, 1, "R2 both restarted");

    // R4: power-down overrides everything
    pd_n = 0;
    observe(1, 1, 1, 1, "R4 before sync");
    #120;
    check(osc_en === 1'b0, "R4 osc_en low", int'(osc_en), 0);
    observe(6, 0, 0, 0, "R4 parked");
    cpu_stop_n = 0; pci_stop_n = 0;
    #40;
    observe(3, 0, 0, 0, "R4 stops ignored low");
    cpu_stop_n = 1; pci_stop_n = 1;
    #40;
    observe(3, 0, 0, 0, "R4 stops ignored high");
    check(osc_en === 1'b0, "R4 osc_en stays low", int'(osc_en), 0);

    // R6: restart from power-down with lock wait
    pd_n = 1;
    n = 0;
    while (osc_en !== 1'b1 && n < 10) begin
      @(negedge pci_clk);
      n++;
    end
    check(osc_en === 1'b1 && n <= 4, "R6 osc_en returns", n, 4);
    #2;
    observe(L, 0, 0, 0, "R6 lock hold");
    #80;
    observe(4, 1, 1, 1, "R6 running after lock");

    // R8: stop requests held through reset
    pd_n = 0;
    #200;
    rst_n = 0; cpu_stop_n = 0; pci_stop_n = 0; pd_n = 1;
    #40;
    rst_n = 1;
    #(PCI_PD * (L + 6));
    observe(4, 0, 0, 1, "R8 stops through reset");
    cpu_stop_n = 1; pci_stop_n = 1;
    #80;
    observe(4, 1, 1, 1, "R8 released");

    // R7: power-down held through reset
    pd_n = 0;
    #200;
    rst_n = 0;
    #40;
    rst_n = 1;
    #100;
    check(osc_en === 1'b0, "R7 osc_en falls with pd held", int'(osc_en), 0);
    observe(L + 2, 0, 0, 0, "R7 pd through reset");
    pd_n = 1;
    #(PCI_PD * (L + 8));
    observe(4, 1, 1, 1, "R7 after pd release");

    finish_run();
  end
endmodule